// File: doc/BRIEF.md
# Register-Access Serial Target with Pointer Auto-Increment

This block lets a two-wire serial bus host (I2C, standard and fast rates up to 400 kHz) read and write an 8-bit wide register file. It decodes a 7-bit target address. The upper five bits of that address are a parameter and the lower two come from a select input, so four targets can share one bus. Clock and data are sampled by the system clock through a two-stage synchroniser. START and STOP are recognised as data edges while the clock line is high. The block pulls the data line low when it acknowledges or sends a zero, and it never stretches the clock.

A write transaction carries a register number first. Each data byte after it goes to the current register, and the pointer then steps up by one. After four data bytes the pointer returns to the register the write started at, and the same four-register cycle repeats. A read transaction that follows a STOP has no register phase. It starts at the register last named by a write and moves to successive registers for as long as the host acknowledges. A repeated START keeps the register number just received. A read after it returns that register, and a write after it stores its first data byte there. The register file is outside the block. The block presents an address, a one-cycle write strobe and write data, and it takes the read data back combinationally. An enable input gates all bus activity.

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges an address byte only when its seven upper bits equal {DEV_HI, addr_sel}. Bit 0 of that byte is 1 for a read and 0 for a write. Any other address is not acknowledged, and the block then ignores the bus until the next START.
- R2: The first byte of a write transaction that follows a STOP is taken as the register number. It produces no write strobe.
- R3: Each further write data byte raises reg_wr_en for one cycle while the clock line is low. The strobe carries the byte and the address start+(k mod 4), where k counts data bytes from 0. The fifth data byte therefore goes to the start register again.
- R4: A read transaction without a register phase sends data MSB first. It starts at the register last named by a write, and the address rises by one for each byte the host acknowledges.
- R5: A register number followed by a repeated START and a read returns that register's data first.
- R6: A register number followed by a repeated START and a write stores the first data byte at that register.
- R7: The block holds the data line low during the ninth clock of every acknowledged byte. It never drives the line while the host sends bits, and a drive it starts always begins while the clock line is low.
- R8: After the host answers a read byte with no-acknowledge, the block stops driving and stays off the bus until the next START.
- R9: While chip_en is low the block drives nothing, acknowledges nothing and issues no write strobe.
- R10: The write strobe is never high for two cycles in a row.
- R11: After reset the data line is released and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Gates all bus activity when low |
| addr_sel | input | 2 | Low two bits of the target address |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_low | output | 1 | 1 pulls the data line low (open drain) |
| reg_addr | output | 8 | Register address for the current access |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Data written with reg_wr_en |
| reg_rdata | input | 8 | Register contents at reg_addr |

## Verification
A wrong pointer offset or an unwrapped offset shows up as a write strobe with an unexpected address. The per-clock write comparison flags it in the same cycle as the bad strobe, one bus byte into the fault. A wrong register-number flag appears as a missing or extra strobe within one byte time. A stale base or a broken increment corrupts the next byte the host reads. A control state that fails to release the line shows up at the next host-driven bit, where the sampled level no longer matches what the host sent.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_RD_ACK
    } tgt_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int NLINES = 2;

    typedef struct packed {
        logic [NLINES-1:0][STAGES-1:0] chain;
        logic [NLINES-1:0]             prev;
    } sync_t;

    sync_t q, d;
    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] now;

    assign raw = {sda_in, scl_in};

    always_comb begin
        d = q;
        for (int i = 0; i < NLINES; i++) begin
            d.chain[i] = {q.chain[i][STAGES-2:0], raw[i]};
            d.prev[i]  = q.chain[i][STAGES-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            assign now[g] = q.chain[g][STAGES-1];
        end
    endgenerate

    assign sda_lvl   = now[1];
    assign scl_rise  = now[0] & ~q.prev[0];
    assign scl_fall  = ~now[0] & q.prev[0];
    assign bus_start = now[0] & q.prev[0] & q.prev[1] & ~now[1];
    assign bus_stop  = now[0] & q.prev[0] & ~q.prev[1] & now[1];
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
    parameter int AW       = 8,
    parameter int WRAP_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_valid,
    input  logic          load_base,
    input  logic [AW-1:0] base_in,
    input  logic          clr_off,
    input  logic          inc_off,
    input  logic          read_mode,
    output logic          ptr_valid,
    output logic [AW-1:0] addr
);
    localparam int WRAP_W = (WRAP_LEN > 1) ? $clog2(WRAP_LEN) : 1;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] off;
        logic          valid;
    } ptr_t;

    ptr_t q, d;
    logic [AW-1:0] wr_off;

    always_comb begin
        d = q;
        if (clr_valid) d.valid = 1'b0;
        if (load_base) begin
            d.base  = base_in;
            d.off   = '0;
            d.valid = 1'b1;
        end
        if (clr_off) d.off = '0;
        if (inc_off) d.off = q.off + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    generate
        if (WRAP_LEN > 1) begin : g_wrap
            assign wr_off = AW'(q.off[WRAP_W-1:0]);
        end else begin : g_nowrap
            assign wr_off = q.off;
        end
    endgenerate

    assign ptr_valid = q.valid;
    assign addr      = q.base + (read_mode ? q.off : wr_off);
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [4:0] DEV_HI      = 5'b10110,
    parameter int         SYNC_STAGES = 2,
    parameter int         WRAP_LEN    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic [1:0]        addr_sel,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_low,
    output logic [BYTE_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int BITC_W = $clog2(BYTE_W) + 1;

    typedef struct packed {
        tgt_state_e        st;
        logic [BITC_W-1:0] bitc;
        logic [BYTE_W-1:0] shift;
        logic              rw;
        logic              ackd;
        logic              drive;
        logic              was_data;
        logic              wr_en;
        logic [BYTE_W-1:0] wdata;
    } ctl_t;

    ctl_t q, d;

    logic sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic clr_valid, load_base, clr_off, inc_off, ptr_valid;
    logic [6:0] my_addr;

    assign my_addr = {DEV_HI, addr_sel};

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    i2c_tgt_ptr #(.AW(BYTE_W), .WRAP_LEN(WRAP_LEN)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_valid(clr_valid),
        .load_base(load_base),
        .base_in  (q.shift),
        .clr_off  (clr_off),
        .inc_off  (inc_off),
        .read_mode(q.rw),
        .ptr_valid(ptr_valid),
        .addr     (reg_addr)
    );

    always_comb begin
        d         = q;
        d.wr_en   = 1'b0;
        clr_valid = 1'b0;
        load_base = 1'b0;
        clr_off   = 1'b0;
        inc_off   = 1'b0;
        if (!chip_en) begin
            d.st      = ST_IDLE;
            d.drive   = 1'b0;
            d.bitc    = '0;
            clr_valid = 1'b1;
        end else if (bus_stop) begin
            d.st      = ST_IDLE;
            d.drive   = 1'b0;
            clr_valid = 1'b1;
        end else if (bus_start) begin
            d.st    = ST_ADDR;
            d.bitc  = '0;
            d.drive = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.shift = {q.shift[BYTE_W-2:0], sda_lvl};
                        d.bitc  = q.bitc + 1'b1;
                    end else if (scl_fall && q.bitc == BITC_W'(BYTE_W)) begin
                        d.bitc = '0;
                        if (q.shift[BYTE_W-1:1] == my_addr) begin
                            d.st    = ST_ADDR_ACK;
                            d.drive = 1'b1;
                            d.rw    = q.shift[0];
                            clr_off = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_rise) begin
                        d.bitc = BITC_W'(1);
                    end else if (scl_fall && q.bitc == BITC_W'(1)) begin
                        d.bitc = '0;
                        if (q.rw) begin
                            d.st    = ST_TX;
                            d.shift = reg_rdata;
                            d.drive = ~reg_rdata[BYTE_W-1];
                        end else begin
                            d.st    = ST_RX;
                            d.drive = 1'b0;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        d.shift = {q.shift[BYTE_W-2:0], sda_lvl};
                        d.bitc  = q.bitc + 1'b1;
                    end else if (scl_fall && q.bitc == BITC_W'(BYTE_W)) begin
                        d.st    = ST_RX_ACK;
                        d.drive = 1'b1;
                        d.bitc  = '0;
                        if (!ptr_valid) begin
                            load_base  = 1'b1;
                            d.was_data = 1'b0;
                        end else begin
                            d.wr_en    = 1'b1;
                            d.wdata    = q.shift;
                            d.was_data = 1'b1;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_rise) begin
                        d.bitc = BITC_W'(1);
                    end else if (scl_fall && q.bitc == BITC_W'(1)) begin
                        d.st    = ST_RX;
                        d.drive = 1'b0;
                        d.bitc  = '0;
                        inc_off = q.was_data;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.bitc = q.bitc + 1'b1;
                    end else if (scl_fall && q.bitc == BITC_W'(BYTE_W)) begin
                        d.st    = ST_RD_ACK;
                        d.drive = 1'b0;
                        d.bitc  = '0;
                        inc_off = 1'b1;
                    end else if (scl_fall && q.bitc != '0) begin
                        d.shift = {q.shift[BYTE_W-2:0], 1'b0};
                        d.drive = ~q.shift[BYTE_W-2];
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.ackd = ~sda_lvl;
                        d.bitc = BITC_W'(1);
                    end else if (scl_fall && q.bitc == BITC_W'(1)) begin
                        d.bitc = '0;
                        if (q.ackd) begin
                            d.st    = ST_TX;
                            d.shift = reg_rdata;
                            d.drive = ~reg_rdata[BYTE_W-1];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_low   = q.drive;
    assign reg_wr_en = q.wr_en;
    assign reg_wdata = q.wdata;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
    input logic clk,
    input logic rst_n,
    input logic chip_en,
    input logic scl_in,
    input logic sda_low,
    input logic reg_wr_en
);
    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    assert_no_write_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(chip_en));

    assert_no_drive_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low |-> $past(chip_en));

    assert_drive_starts_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low) |-> !scl_in);

    assert_strobe_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !scl_in);
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_en  (chip_en),
    .scl_in   (scl_in),
    .sda_low  (sda_low),
    .reg_wr_en(reg_wr_en)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
    localparam logic [4:0] DEV_HI = 5'b10110;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_en = 1'b1;
    logic [1:0] addr_sel = 2'b01;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_low, reg_wr_en;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic sda_line;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] dmem [256];
    logic [7:0] ref_mem [256];
    logic [15:0] exp_q [$];

    always #2 clk = ~clk;

    assign sda_line  = sda_drv & ~sda_low;
    assign reg_rdata = dmem[reg_addr];

    i2c_reg_target #(.DEV_HI(DEV_HI)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_en  (chip_en),
        .addr_sel (addr_sel),
        .scl_in   (scl_drv),
        .sda_in   (sda_line),
        .sda_low  (sda_low),
        .reg_addr (reg_addr),
        .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) dmem[i] <= 8'(i) ^ 8'h5A;
        end else if (reg_wr_en) begin
            dmem[reg_addr] <= reg_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock reference comparison of write strobes (R2, R3, R9)
    always @(negedge clk) begin
        if (rst_n && reg_wr_en) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2_R9 unexpected strobe", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk({reg_addr, reg_wdata} == e, "R3 write addr/data", {reg_addr, reg_wdata}, e);
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_wr(input logic [7:0] a, input logic [7:0] v);
        exp_q.push_back({a, v});
        ref_mem[a] = v;
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; wt(Q);
        scl_drv = 1'b1; wt(Q);
        sda_drv = 1'b0; wt(Q);
        scl_drv = 1'b0; wt(Q);
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; wt(Q);
        scl_drv = 1'b1; wt(Q);
        sda_drv = 1'b1; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wt(Q);
            scl_drv = 1'b1; wt(Q);
            chk(sda_line == b[i], "R7 line follows host bit", sda_line, b[i]);
            scl_drv = 1'b0; wt(Q);
        end
        sda_drv = 1'b1; wt(Q);
        scl_drv = 1'b1; wt(Q);
        acked = (sda_line == 1'b0);
        scl_drv = 1'b0; wt(Q);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        sda_drv = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wt(Q);
            scl_drv = 1'b1; wt(Q);
            b = {b[6:0], sda_line};
            scl_drv = 1'b0;
        end
        wt(Q);
        sda_drv = ~ack; wt(Q);
        scl_drv = 1'b1; wt(Q);
        chk(sda_low == 1'b0, "R8 released in host ack bit", sda_low, 0);
        scl_drv = 1'b0; wt(Q);
        sda_drv = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic [1:0] sel, input bit rd);
        return {DEV_HI, sel, rd};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] r;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i) ^ 8'h5A;
        wt(5);
        // R11 reset state
        chk(sda_low == 1'b0, "R11 sda released in reset", sda_low, 0);
        chk(reg_wr_en == 1'b0, "R11 no strobe in reset", reg_wr_en, 0);
        rst_n = 1'b1;
        wt(10);
        chk(sda_low == 1'b0, "R11 sda released after reset", sda_low, 0);

        // R1 R2 R3: sequential write with wrap after four data bytes
        bus_start;
        send_byte(dev(2'b01, 0), a); chk(a, "R1 address ack", a, 1);
        send_byte(8'h10, a); chk(a, "R7 register byte ack", a, 1);
        for (int k = 0; k < 6; k++) begin
            exp_wr(8'h10 + 8'(k % 4), 8'hA0 + 8'(k));
            send_byte(8'hA0 + 8'(k), a); chk(a, "R7 data ack", a, 1);
        end
        bus_stop;
        chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);

        // R4 read without register phase, R8 release after NACK
        bus_start;
        send_byte(dev(2'b01, 1), a); chk(a, "R1 read address ack", a, 1);
        for (int k = 0; k < 3; k++) begin
            recv_byte(k != 2, r);
            chk(r == ref_mem[8'h10 + 8'(k)], "R4 sequential read", r, ref_mem[8'h10 + 8'(k)]);
        end
        wt(Q);
        chk(sda_low == 1'b0, "R8 idle after nack", sda_low, 0);
        bus_stop;

        // R5 combined write-register then read
        bus_start;
        send_byte(dev(2'b01, 0), a);
        send_byte(8'h20, a);
        bus_start;
        send_byte(dev(2'b01, 1), a); chk(a, "R5 restart read ack", a, 1);
        recv_byte(0, r);
        chk(r == ref_mem[8'h20], "R5 combined read", r, ref_mem[8'h20]);
        bus_stop;

        // R6 combined write-register then write data
        bus_start;
        send_byte(dev(2'b01, 0), a);
        send_byte(8'h30, a);
        bus_start;
        send_byte(dev(2'b01, 0), a); chk(a, "R6 restart write ack", a, 1);
        exp_wr(8'h30, 8'h77);
        send_byte(8'h77, a); chk(a, "R6 data ack", a, 1);
        bus_stop;
        chk(exp_q.size() == 0, "R6 write seen", exp_q.size(), 0);

        // R1 wrong address ignored
        bus_start;
        send_byte(dev(2'b10, 0), a); chk(!a, "R1 wrong address nack", a, 0);
        send_byte(8'h55, a); chk(!a, "R1 ignored after mismatch", a, 0);
        bus_stop;

        // R1 address select change
        addr_sel = 2'b10;
        bus_start;
        send_byte(dev(2'b10, 0), a); chk(a, "R1 new select ack", a, 1);
        send_byte(8'h40, a);
        exp_wr(8'h40, 8'h11);
        send_byte(8'h11, a);
        bus_stop;

        // R9 chip enable low
        chip_en = 1'b0;
        bus_start;
        send_byte(dev(2'b10, 0), a); chk(!a, "R9 no ack when disabled", a, 0);
        send_byte(8'h50, a); chk(!a, "R9 no ack byte", a, 0);
        bus_stop;
        chip_en = 1'b1;
        wt(Q);

        // R4 read restarts at last written register number
        bus_start;
        send_byte(dev(2'b10, 1), a); chk(a, "R4 read ack", a, 1);
        recv_byte(1, r); chk(r == ref_mem[8'h40], "R4 read base", r, ref_mem[8'h40]);
        recv_byte(0, r); chk(r == ref_mem[8'h41], "R4 read next", r, ref_mem[8'h41]);
        bus_stop;
        wt(20);
        chk(exp_q.size() == 0, "R3 no pending writes", exp_q.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule